// File: doc/BRIEF.md
# Phase-Parity Transaction Barrier Bank

This block holds a small bank of reusable synchronization barriers. Each barrier is one 64-bit word with five fields: a valid bit, a phase bit, a signed byte ledger, an expected arrival total and a running arrival count. A barrier completes when two things are true at once. Its arrival count must equal the programmed total, and its byte ledger must be exactly zero. On completion the count and the ledger clear and the phase bit inverts, so the barrier is ready for the next round with no reprogramming.

Requests reach the bank through four paths:
- **Local port.** One operation per cycle: init, arrive, or arrive with declared bytes.
- **Peer port.** Arrivals from a neighbouring unit. Each carries a rank, and the bank accepts only arrivals whose rank equals its own.
- **Credit port.** Byte completions reported by a copy engine.
- **Wait port.** A parity query. It returns a registered release one cycle later when the barrier's phase differs from the parity supplied.

A local arrival and a peer arrival on the same barrier in the same cycle are both counted. Misuse raises one sticky error flag. Misuse means an arrival past the programmed total, any operation on a barrier that was never set up, an init with a zero total, or another operation racing an init.

Top module: `barrier_unit`

## Requirements
- R1: Local op encoding is 0 nop, 1 init, 2 arrive, 3 arrive-with-bytes. An init with a nonzero total (low 8 bits of `arg_i`) marks the barrier valid, loads the total, clears count and ledger, and sets phase to 0. An init with total 0 leaves the barrier invalid and raises `err_o`.
- R2: A peer arrival or byte credit that targets a barrier in the same cycle as that barrier's init is dropped and raises `err_o`. Only later cycles count.
- R3: Each accepted arrival adds one to the count. When the count equals the total and the ledger is zero, the count and ledger clear and the phase inverts at that clock edge. `phase_o[b]` shows the new phase right after the edge.
- R4: A local arrival and an accepted peer arrival on the same barrier in one cycle add two, and completion is judged on the combined count.
- R5: Arrive-with-bytes adds `arg_i` to the signed ledger as well as counting one arrival. A credit subtracts `cred_bytes_i`. A credit that arrives early may drive the ledger negative, and completion needs the ledger to be exactly zero.
- R6: If the arrivals in a cycle would push the count above the total, they are dropped together with their bytes and `err_o` is raised. Credits in that cycle still apply. `err_o` stays high until reset.
- R7: Any arrival or credit aimed at an invalid barrier raises `err_o` and changes nothing.
- R8: A peer arrival whose `peer_rank_i` differs from parameter `MY_RANK` (default 1) is ignored, with no error.
- R9: `wait_done_o` is high in the cycle after a sampled wait request exactly when the target barrier was valid and its phase before that edge differed from `wait_par_i`. A waiter on the parity in force before the flip is never released early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| op_i | input | 2 | Local operation code |
| bar_i | input | 2 | Local target barrier |
| arg_i | input | 16 | Init total (low 8 bits) or declared bytes |
| peer_vld_i | input | 1 | Peer arrival valid |
| peer_rank_i | input | 2 | Rank the peer arrival is addressed to |
| peer_bar_i | input | 2 | Peer target barrier |
| cred_vld_i | input | 1 | Byte credit valid |
| cred_bar_i | input | 2 | Credit target barrier |
| cred_bytes_i | input | 16 | Completed bytes |
| wait_vld_i | input | 1 | Wait query valid |
| wait_bar_i | input | 2 | Wait target barrier |
| wait_par_i | input | 1 | Parity the waiter holds |
| wait_done_o | output | 1 | Registered wait release |
| phase_o | output | 4 | Current phase of each barrier |
| err_o | output | 1 | Sticky misuse flag |

## Verification
The bench targets several corner cases, each with the failure it would expose:
- **Simultaneous local and peer arrival.** A design that counts only one of them completes one arrival late.
- **Credit before its matching expect.** A design with an unsigned ledger either saturates at zero or completes early.
- **Wait issued in the completion cycle.** A design that compares against the next phase instead of the registered one releases the old-parity waiter early. A later wait on the new parity must stay low, or the design is double-releasing.
- **Overflow and init races.** A design that keeps the dropped arrivals shows up as a phase flip one arrival too soon.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  localparam int CNT_W  = 8;
  localparam int BYTE_W = 16;
  localparam int LED_W  = BYTE_W + 2;
  localparam int WORD_W = 64;
  localparam int PAD_W  = WORD_W - 2 - LED_W - 2 * CNT_W;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_INIT  = 2'd1,
    OP_ARR   = 2'd2,
    OP_ARRTX = 2'd3
  } op_e;

  typedef struct packed {
    logic [PAD_W-1:0]        rsvd;
    logic                    valid;
    logic                    phase;
    logic signed [LED_W-1:0] led;
    logic [CNT_W-1:0]        exp;
    logic [CNT_W-1:0]        cnt;
  } bar_word_t;
endpackage

// File: rtl/bar_slot.sv
module bar_slot import barrier_pkg::*; (
  input  bar_word_t         cur_i,
  input  logic              init_en_i,
  input  logic [CNT_W-1:0]  init_exp_i,
  input  logic              loc_arr_i,
  input  logic [BYTE_W-1:0] loc_bytes_i,
  input  logic              peer_arr_i,
  input  logic              cred_en_i,
  input  logic [BYTE_W-1:0] cred_bytes_i,
  output bar_word_t         nxt_o,
  output logic              err_o
);
  logic [1:0]              inc;
  logic [CNT_W:0]          sum;
  logic signed [LED_W-1:0] add_b, sub_b, led_n;
  logic [CNT_W-1:0]        cnt_n;

  always_comb begin
    nxt_o = cur_i;
    err_o = 1'b0;
    inc   = {1'b0, loc_arr_i} + {1'b0, peer_arr_i};
    sum   = {1'b0, cur_i.cnt} + {{(CNT_W-1){1'b0}}, inc};
    add_b = loc_arr_i ? $signed({2'b00, loc_bytes_i}) : '0;
    sub_b = cred_en_i ? $signed({2'b00, cred_bytes_i}) : '0;
    led_n = cur_i.led;
    cnt_n = cur_i.cnt;
    if (init_en_i) begin
      // fence: racing ops to the barrier being set up are dropped
      if (peer_arr_i || cred_en_i) err_o = 1'b1;
      nxt_o = '0;
      if (init_exp_i == '0) begin
        err_o = 1'b1;
      end else begin
        nxt_o.valid = 1'b1;
        nxt_o.exp   = init_exp_i;
      end
    end else if (!cur_i.valid) begin
      if (loc_arr_i || peer_arr_i || cred_en_i) err_o = 1'b1;
    end else begin
      led_n = cur_i.led - sub_b;
      if (sum > {1'b0, cur_i.exp}) begin
        err_o = 1'b1;
      end else begin
        cnt_n = sum[CNT_W-1:0];
        led_n = led_n + add_b;
      end
      if (cnt_n == cur_i.exp && led_n == '0) begin
        nxt_o.cnt   = '0;
        nxt_o.led   = '0;
        nxt_o.phase = ~cur_i.phase;
      end else begin
        nxt_o.cnt = cnt_n;
        nxt_o.led = led_n;
      end
    end
  end
endmodule

// File: rtl/wait_port.sv
module wait_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic valid_i,
  input  logic phase_i,
  input  logic par_i,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_o <= 1'b0;
    else         done_o <= vld_i && valid_i && (phase_i != par_i);
  end

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(vld_i)); // R9
  AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && phase_i == par_i) |=> !done_o); // R9
endmodule

// File: rtl/barrier_unit.sv
module barrier_unit import barrier_pkg::*; #(
  parameter int NUM_BAR = 4,
  parameter int RANK_W  = 2,
  parameter int MY_RANK = 1,
  localparam int BAR_W  = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         op_i,
  input  logic [BAR_W-1:0]   bar_i,
  input  logic [BYTE_W-1:0]  arg_i,
  input  logic               peer_vld_i,
  input  logic [RANK_W-1:0]  peer_rank_i,
  input  logic [BAR_W-1:0]   peer_bar_i,
  input  logic               cred_vld_i,
  input  logic [BAR_W-1:0]   cred_bar_i,
  input  logic [BYTE_W-1:0]  cred_bytes_i,
  input  logic               wait_vld_i,
  input  logic [BAR_W-1:0]   wait_bar_i,
  input  logic               wait_par_i,
  output logic               wait_done_o,
  output logic [NUM_BAR-1:0] phase_o,
  output logic               err_o
);
  op_e          op;
  logic         peer_ok;
  bar_word_t    state_q [NUM_BAR];
  bar_word_t    state_n [NUM_BAR];
  logic [NUM_BAR-1:0] slot_err, init_en;

  assign op      = op_e'(op_i);
  assign peer_ok = peer_vld_i && (peer_rank_i == RANK_W'(MY_RANK));

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
    logic hit;
    assign hit        = (bar_i == BAR_W'(b));
    assign init_en[b] = hit && (op == OP_INIT);

    bar_slot u_slot (
      .cur_i        (state_q[b]),
      .init_en_i    (init_en[b]),
      .init_exp_i   (arg_i[CNT_W-1:0]),
      .loc_arr_i    (hit && (op == OP_ARR || op == OP_ARRTX)),
      .loc_bytes_i  ((op == OP_ARRTX) ? arg_i : '0),
      .peer_arr_i   (peer_ok && (peer_bar_i == BAR_W'(b))),
      .cred_en_i    (cred_vld_i && (cred_bar_i == BAR_W'(b))),
      .cred_bytes_i (cred_bytes_i),
      .nxt_o        (state_n[b]),
      .err_o        (slot_err[b])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q[b] <= '0;
      else         state_q[b] <= state_n[b];
    end

    assign phase_o[b] = state_q[b].phase;

    AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (init_en[b] && arg_i[CNT_W-1:0] != '0) |=>
      (state_q[b].valid && !state_q[b].phase && state_q[b].cnt == '0)); // R1
    AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q[b].valid |-> (state_q[b].cnt <= state_q[b].exp)); // R6
    AST_FLIP_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q[b].valid && !init_en[b]) |=>
      ($stable(state_q[b].phase) || (state_q[b].cnt == '0 && state_q[b].led == '0))); // R3
    AST_UNINIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!state_q[b].valid && !init_en[b]) |=> $stable(state_q[b])); // R7
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= err_o | (|slot_err);
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R6

  wait_port u_wait (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (wait_vld_i),
    .valid_i (state_q[wait_bar_i].valid),
    .phase_i (state_q[wait_bar_i].phase),
    .par_i   (wait_par_i),
    .done_o  (wait_done_o)
  );
endmodule

// File: tb/sim_barrier_unit.sv
`timescale 1ns/1ps
module sim_barrier_unit;
  localparam int NB = 4;
  localparam int MY = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] op;  logic [1:0] bar;  logic [15:0] arg;
  logic pv;  logic [1:0] prank, pbar;
  logic cv;  logic [1:0] cbar;  logic [15:0] cbytes;
  logic wv;  logic [1:0] wbar;  logic wpar;
  logic wait_done;  logic [NB-1:0] phase;  logic err;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  int  m_cnt [NB], m_exp [NB], m_led [NB];
  bit  m_valid [NB], m_phase [NB];
  bit  m_err;

  always #4 clk = ~clk;

  barrier_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .bar_i(bar), .arg_i(arg),
    .peer_vld_i(pv), .peer_rank_i(prank), .peer_bar_i(pbar),
    .cred_vld_i(cv), .cred_bar_i(cbar), .cred_bytes_i(cbytes),
    .wait_vld_i(wv), .wait_bar_i(wbar), .wait_par_i(wpar),
    .wait_done_o(wait_done), .phase_o(phase), .err_o(err)
  );

  task automatic clr();
    op = 2'd0; bar = '0; arg = '0; pv = 0; prank = '0; pbar = '0;
    cv = 0; cbar = '0; cbytes = '0; wv = 0; wbar = '0; wpar = 0;
  endtask

  task automatic chk(string tag, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic do_reset();
    clr();
    rst_ni = 1'b0;
    for (int b = 0; b < NB; b++) begin
      m_cnt[b] = 0; m_exp[b] = 0; m_led[b] = 0; m_valid[b] = 0; m_phase[b] = 0;
    end
    m_err = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  function automatic int phase_vec();
    int v = 0;
    for (int b = 0; b < NB; b++) v |= int'(m_phase[b]) << b;
    return v;
  endfunction

  // one cycle: predict from requirements, clock, compare
  task automatic step(string tag);
    bit exp_done;
    exp_done = wv && m_valid[wbar] && (m_phase[wbar] != wpar);
    for (int b = 0; b < NB; b++) begin
      bit ie, la, pa, ce;
      int inc, lb, cb, cn, ln;
      ie = (op == 2'd1) && (bar == b);
      la = (op == 2'd2 || op == 2'd3) && (bar == b);
      lb = (op == 2'd3) ? int'(arg) : 0;
      pa = pv && (prank == MY) && (pbar == b);
      ce = cv && (cbar == b);
      cb = ce ? int'(cbytes) : 0;
      if (ie) begin
        if (pa || ce) m_err = 1;
        m_cnt[b] = 0; m_led[b] = 0; m_phase[b] = 0;
        m_exp[b] = int'(arg[7:0]);
        m_valid[b] = (arg[7:0] != 0);
        if (arg[7:0] == 0) m_err = 1;
      end else if (!m_valid[b]) begin
        if (la || pa || ce) m_err = 1;
      end else begin
        inc = int'(la) + int'(pa);
        ln = m_led[b] - cb;
        cn = m_cnt[b];
        if (m_cnt[b] + inc > m_exp[b]) m_err = 1;
        else begin cn = m_cnt[b] + inc; if (la) ln += lb; end
        if (cn == m_exp[b] && ln == 0) begin
          m_cnt[b] = 0; m_led[b] = 0; m_phase[b] = !m_phase[b];
        end else begin
          m_cnt[b] = cn; m_led[b] = ln;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " phase"}, int'(phase), phase_vec());
    chk({tag, " err"}, int'(err), int'(m_err));
    chk({tag, " wait"}, int'(wait_done), int'(exp_done));
    clr();
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clr();
    do_reset();
    chk("R1 reset phase", int'(phase), 0);
    chk("R1 reset err", int'(err), 0);
    chk("R9 reset wait", int'(wait_done), 0);

    // R1 / R3 / R4 / R9
    op = 2'd1; bar = 0; arg = 16'd3; wv = 1; wbar = 0; wpar = 0; step("R1 init");
    op = 2'd2; bar = 0; wv = 1; wbar = 0; wpar = 0; step("R3 arrive one");
    op = 2'd2; bar = 0; pv = 1; prank = 2'(MY); pbar = 0; wv = 1; wpar = 0;
    step("R4 dual arrive, R9 no early");
    wv = 1; wbar = 0; wpar = 0; step("R9 release old parity");
    wv = 1; wbar = 0; wpar = 1; step("R9 new parity holds");
    // R8
    pv = 1; prank = 2'd2; pbar = 0; step("R8 wrong rank");
    op = 2'd2; bar = 0; step("R8 arrive a");
    op = 2'd2; bar = 0; step("R8 arrive b");
    op = 2'd2; bar = 0; step("R8 arrive c completes");
    // R5
    op = 2'd1; bar = 1; arg = 16'd1; step("R5 init");
    cv = 1; cbar = 1; cbytes = 16'd5; step("R5 early credit");
    op = 2'd3; bar = 1; arg = 16'd5; step("R5 expect cancels");
    op = 2'd3; bar = 1; arg = 16'd4; step("R5 expect pending");
    cv = 1; cbar = 1; cbytes = 16'd3; step("R5 partial credit");
    cv = 1; cbar = 1; cbytes = 16'd1; step("R5 final credit");
    // R2
    op = 2'd1; bar = 2; arg = 16'd2; pv = 1; prank = 2'(MY); pbar = 2; step("R2 race");
    op = 2'd2; bar = 2; step("R2 arrive a");
    op = 2'd2; bar = 2; step("R2 arrive b");

    // R6
    do_reset();
    op = 2'd1; bar = 0; arg = 16'd1; step("R6 init");
    op = 2'd2; bar = 0; pv = 1; prank = 2'(MY); pbar = 0; step("R6 overflow");
    step("R6 sticky");
    op = 2'd2; bar = 0; step("R6 arrive after drop");

    // R7
    do_reset();
    op = 2'd2; bar = 3; step("R7 uninit arrive");
    op = 2'd1; bar = 3; arg = 16'd1; step("R7 init");
    op = 2'd2; bar = 3; step("R7 arrive completes");

    // R1 zero total
    do_reset();
    op = 2'd1; bar = 1; arg = 16'd0; step("R1 zero total");
    wv = 1; wbar = 1; wpar = 1; step("R9 invalid no release");

    // random mix
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 15);
      bar = 2'($urandom_range(0, 3));
      if (r == 0) begin op = 2'd1; arg = 16'($urandom_range(1, 4)); end
      else if (r < 4) op = 2'd0;
      else if (r < 10) op = 2'd2;
      else begin op = 2'd3; arg = 16'($urandom_range(0, 15)); end
      pv = ($urandom_range(0, 2) == 0); prank = 2'($urandom_range(0, 3));
      pbar = 2'($urandom_range(0, 3));
      cv = ($urandom_range(0, 3) == 0); cbar = 2'($urandom_range(0, 3));
      cbytes = 16'($urandom_range(0, 15));
      wv = 1'($urandom_range(0, 1)); wbar = 2'($urandom_range(0, 3));
      wpar = 1'($urandom_range(0, 1));
      step("R3 random");
      if (i % 500 == 499) do_reset();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule